// File: doc/BRIEF.md
# Password-Gated Trim Register File

This block is the register file behind a two-channel digital trim resistor. It has 32 byte addresses. They hold a device address byte, a configuration byte with one high-impedance bit per channel, and two 8-bit position codes. They also hold a 16-bit volatile password entry, a 16-bit stored password setting, and sixteen general-purpose user bytes. A bus slave in front of it presents one byte access per clock cycle: an address, a write strobe and write data. The block returns read data combinationally and flags in the same cycle whether a write was accepted, so that a downstream commit controller records only accepted bytes.

Write access is gated by comparing the entry with the setting. When they are equal, every implemented location is writable. When they differ, only the entry bytes accept writes, and the setting becomes unreadable. The comparison is made every cycle against the current register contents. A write that changes the entry or the setting therefore takes effect on the access in the next cycle. The block drives the two position codes and the two high-impedance enables to the resistor ladders.

Top module: `trim_regfile`

## Requirements
- R1: After reset, both position outputs are 7Fh and both high-impedance enables are 0. Address 00h reads A0h, the user bytes read FFh, and the entry and setting both hold FFFFh, so the file starts unlocked.
- R2: While the entry equals the setting, a write to 00h–03h, 06h–07h or 10h–1Fh raises the write-accepted flag in its cycle, and the byte reads back afterwards.
- R3: While the entry differs from the setting, a write to any address outside 04h–05h is refused: the flag stays low and the location keeps its value.
- R4: Writes to 04h (high byte of the entry) and 05h (low byte) are always accepted. Reads of 04h–05h always return FFh.
- R5: Reads of 06h (high byte of the setting) and 07h (low byte) return the stored byte when the entry equals the setting, and FFh otherwise.
- R6: Configuration byte 01h: bit 0 drives the channel 0 high-impedance enable, and bit 1 drives the channel 1 enable. Bits 7:2 read as 0. Clearing a bit leaves the position code unchanged.
- R7: The channel 0 position output equals byte 02h and the channel 1 position output equals byte 03h (00h is minimum, FFh is maximum). Each updates on the clock edge that ends an accepted write.
- R8: Addresses 08h–0Fh read FFh and never accept a write.
- R9: The password comparison uses the register contents of the current cycle. A write that breaks the match refuses the next write to a protected address, while further entry writes are still accepted.
- R10: The write-accepted flag is never high in a cycle without a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_addr | input | 5 | Byte address of the current access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| bus_wr_ok | output | 1 | Write at bus_addr accepted this cycle |
| pos0_code | output | 8 | Channel 0 position code |
| pos1_code | output | 8 | Channel 1 position code |
| hiz0_en | output | 1 | Channel 0 high-impedance enable |
| hiz1_en | output | 1 | Channel 1 high-impedance enable |

## Verification
A wrong lock state appears in the same cycle as a wrong write-accepted flag. It also appears as a setting byte that reads FFh when it should read back, or the reverse. A corrupted position or configuration register appears on the ladder outputs one edge after the write that caused it. The bench therefore checks the flag inside the write cycle and the outputs right after the edge. It walks through the sequence that arms the password, where each step flips the lock for the step that follows. This catches comparison timing that is off by one cycle.

// File: rtl/trim_regfile_pkg.sv
package trim_regfile_pkg;
  localparam int AW     = 5;
  localparam int DW     = 8;
  localparam int PW     = 2 * DW;
  localparam int USER_N = 1 << (AW - 1);
  localparam int UIW    = AW - 1;

  typedef enum logic [2:0] {
    RG_DEVADR,
    RG_CFG,
    RG_POS,
    RG_PIN,
    RG_PSET,
    RG_HOLE,
    RG_USER
  } region_e;

  function automatic region_e region_of(input logic [AW-1:0] a);
    region_e r;
    if (a[AW-1]) begin
      r = RG_USER;
    end else if (a[3]) begin
      r = RG_HOLE;
    end else begin
      case (a[2:1])
        2'b00:   r = a[0] ? RG_CFG : RG_DEVADR;
        2'b01:   r = RG_POS;
        2'b10:   r = RG_PIN;
        default: r = RG_PSET;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/trim_pw_gate.sv
module trim_pw_gate
  import trim_regfile_pkg::*;
(
  input  logic [PW-1:0] pin_q,
  input  logic [PW-1:0] pset_q,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic          unlocked,
  output logic          wr_ok
);
  region_e reg_sel;

  always_comb begin
    reg_sel  = region_of(addr);
    unlocked = (pin_q == pset_q);
    wr_ok    = wr && ((reg_sel == RG_PIN) ||
                      (unlocked && (reg_sel != RG_HOLE)));
  end
endmodule

// File: rtl/trim_reg_bank.sv
module trim_reg_bank
  import trim_regfile_pkg::*;
#(
  parameter logic [DW-1:0] DEF_DEVADR = 8'hA0,
  parameter logic [DW-1:0] DEF_POS    = 8'h7F,
  parameter logic [PW-1:0] DEF_PSET   = 16'hFFFF,
  parameter logic [DW-1:0] DEF_USER   = 8'hFF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            devadr_q,
  output logic [1:0]               cfg_q,
  output logic [1:0][DW-1:0]       pos_q,
  output logic [PW-1:0]            pin_q,
  output logic [PW-1:0]            pset_q,
  output logic [USER_N-1:0][DW-1:0] user_q
);
  localparam logic [PW-1:0] PIN_RESET = '1;

  region_e reg_sel;
  logic [DW-1:0]      devadr_d;
  logic [1:0]         cfg_d;
  logic [1:0][DW-1:0] pos_d;
  logic [PW-1:0]      pin_d;
  logic [PW-1:0]      pset_d;

  always_comb begin
    reg_sel  = region_of(addr);
    devadr_d = devadr_q;
    cfg_d    = cfg_q;
    pos_d    = pos_q;
    pin_d    = pin_q;
    pset_d   = pset_q;
    if (we) begin
      case (reg_sel)
        RG_DEVADR: devadr_d = wdata;
        RG_CFG:    cfg_d = wdata[1:0];
        RG_POS:    pos_d[addr[0]] = wdata;
        RG_PIN:    if (addr[0]) pin_d[DW-1:0] = wdata;
                   else         pin_d[PW-1:DW] = wdata;
        RG_PSET:   if (addr[0]) pset_d[DW-1:0] = wdata;
                   else         pset_d[PW-1:DW] = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devadr_q <= DEF_DEVADR;
      cfg_q    <= '0;
      pos_q    <= {DEF_POS, DEF_POS};
      pin_q    <= PIN_RESET;
      pset_q   <= DEF_PSET;
    end else begin
      devadr_q <= devadr_d;
      cfg_q    <= cfg_d;
      pos_q    <= pos_d;
      pin_q    <= pin_d;
      pset_q   <= pset_d;
    end
  end

  for (genvar i = 0; i < USER_N; i++) begin : g_user
    logic hit;
    assign hit = we && (reg_sel == RG_USER) && (addr[UIW-1:0] == UIW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   user_q[i] <= DEF_USER;
      else if (hit) user_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/trim_rd_mux.sv
module trim_rd_mux
  import trim_regfile_pkg::*;
(
  input  logic [AW-1:0]             addr,
  input  logic                      unlocked,
  input  logic [DW-1:0]             devadr_q,
  input  logic [1:0]                cfg_q,
  input  logic [1:0][DW-1:0]        pos_q,
  input  logic [PW-1:0]             pset_q,
  input  logic [USER_N-1:0][DW-1:0] user_q,
  output logic [DW-1:0]             rdata
);
  region_e reg_sel;

  always_comb begin
    reg_sel = region_of(addr);
    rdata   = '1;
    case (reg_sel)
      RG_DEVADR: rdata = devadr_q;
      RG_CFG:    rdata = {{(DW-2){1'b0}}, cfg_q};
      RG_POS:    rdata = pos_q[addr[0]];
      RG_PSET:   if (unlocked)
                   rdata = addr[0] ? pset_q[DW-1:0] : pset_q[PW-1:DW];
      RG_USER:   rdata = user_q[addr[UIW-1:0]];
      default:   rdata = '1;
    endcase
  end
endmodule

// File: rtl/trim_regfile.sv
module trim_regfile
  import trim_regfile_pkg::*;
#(
  parameter logic [7:0]  DEF_DEVADR = 8'hA0,
  parameter logic [7:0]  DEF_POS    = 8'h7F,
  parameter logic [15:0] DEF_PSET   = 16'hFFFF,
  parameter logic [7:0]  DEF_USER   = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [4:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_wr_ok,
  output logic [7:0] pos0_code,
  output logic [7:0] pos1_code,
  output logic       hiz0_en,
  output logic       hiz1_en
);
  logic                      unlocked;
  logic [DW-1:0]             devadr_q;
  logic [1:0]                cfg_q;
  logic [1:0][DW-1:0]        pos_q;
  logic [PW-1:0]             pin_q;
  logic [PW-1:0]             pset_q;
  logic [USER_N-1:0][DW-1:0] user_q;

  trim_pw_gate u_gate (
    .pin_q   (pin_q),
    .pset_q  (pset_q),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .unlocked(unlocked),
    .wr_ok   (bus_wr_ok)
  );

  trim_reg_bank #(
    .DEF_DEVADR(DEF_DEVADR),
    .DEF_POS   (DEF_POS),
    .DEF_PSET  (DEF_PSET),
    .DEF_USER  (DEF_USER)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_wr_ok),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .devadr_q(devadr_q),
    .cfg_q   (cfg_q),
    .pos_q   (pos_q),
    .pin_q   (pin_q),
    .pset_q  (pset_q),
    .user_q  (user_q)
  );

  trim_rd_mux u_rd (
    .addr    (bus_addr),
    .unlocked(unlocked),
    .devadr_q(devadr_q),
    .cfg_q   (cfg_q),
    .pos_q   (pos_q),
    .pset_q  (pset_q),
    .user_q  (user_q),
    .rdata   (bus_rdata)
  );

  assign pos0_code = pos_q[0];
  assign pos1_code = pos_q[1];
  assign hiz0_en   = cfg_q[0];
  assign hiz1_en   = cfg_q[1];
endmodule

// File: rtl/trim_regfile_chk.sv
module trim_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [4:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       bus_wr_ok,
  input logic [7:0] pos0_code,
  input logic [7:0] pos1_code,
  input logic       hiz0_en,
  input logic       hiz1_en,
  input logic       unlocked
);
  a_r10_no_strobe_no_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> !bus_wr_ok);

  a_r4_entry_always_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4:1] == 4'h2) |-> bus_wr_ok);

  a_r4_entry_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[4:1] == 4'h2) |-> (bus_rdata == 8'hFF));

  a_r5_setting_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_addr[4:1] == 4'h3) |-> (bus_rdata == 8'hFF));

  a_r8_hole_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4:3] == 2'b01) |-> !bus_wr_ok);

  a_r3_locked_pos_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_wr) |=> ($stable(pos0_code) && $stable(pos1_code)
                               && $stable(hiz0_en) && $stable(hiz1_en)));

  a_r7_pos0_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_ok && bus_addr == 5'h02) |=> (pos0_code == $past(bus_wdata)));

  a_r7_pos1_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_ok && bus_addr == 5'h03) |=> (pos1_code == $past(bus_wdata)));

  a_r6_cfg_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_ok && bus_addr == 5'h01) |=>
      ({hiz1_en, hiz0_en} == $past(bus_wdata[1:0])));
endmodule

bind trim_regfile trim_regfile_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .bus_wr_ok(bus_wr_ok),
  .pos0_code(pos0_code),
  .pos1_code(pos1_code),
  .hiz0_en  (hiz0_en),
  .hiz1_en  (hiz1_en),
  .unlocked (unlocked)
);

// File: tb/tb_trim_regfile.sv
`timescale 1ns/1ps
module tb_trim_regfile;
  logic       clk;
  logic       rst_n;
  logic       bus_wr;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       bus_wr_ok;
  logic [7:0] pos0_code, pos1_code;
  logic       hiz0_en, hiz1_en;

  int total = 0;
  int bad   = 0;

  trim_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wr_ok(bus_wr_ok),
    .pos0_code(pos0_code), .pos1_code(pos1_code),
    .hiz0_en(hiz0_en), .hiz1_en(hiz1_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Write in one cycle; check the accept flag before the edge.
  task automatic wr_byte(input string req, input logic [4:0] a, input logic [7:0] d,
                         input logic exp_ok);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    check(req, {7'b0, bus_wr_ok}, {7'b0, exp_ok});
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_byte(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    check("R1 pos0", pos0_code, 8'h7F);
    check("R1 pos1", pos1_code, 8'h7F);
    check("R1 hiz", {6'b0, hiz1_en, hiz0_en}, 8'h00);
    rd_byte("R1 devadr", 5'h00, 8'hA0);
    rd_byte("R1 user", 5'h17, 8'hFF);
    rd_byte("R1 setting default", 5'h06, 8'hFF);
  endtask

  task automatic t_unlocked;
    wr_byte("R2 pos0 write", 5'h02, 8'h12, 1'b1);
    check("R7 pos0", pos0_code, 8'h12);
    wr_byte("R2 pos1 write", 5'h03, 8'hFE, 1'b1);
    check("R7 pos1", pos1_code, 8'hFE);
    wr_byte("R2 user lo", 5'h10, 8'h5A, 1'b1);
    wr_byte("R2 user hi", 5'h1F, 8'hC3, 1'b1);
    wr_byte("R2 devadr", 5'h00, 8'hB4, 1'b1);
    rd_byte("R2 user lo rb", 5'h10, 8'h5A);
    rd_byte("R2 user hi rb", 5'h1F, 8'hC3);
    rd_byte("R2 devadr rb", 5'h00, 8'hB4);
    rd_byte("R7 pos1 rb", 5'h03, 8'hFE);
  endtask

  task automatic t_config;
    wr_byte("R6 cfg both", 5'h01, 8'h03, 1'b1);
    check("R6 hiz both", {6'b0, hiz1_en, hiz0_en}, 8'h03);
    rd_byte("R6 cfg rb", 5'h01, 8'h03);
    wr_byte("R6 cfg ch1 only", 5'h01, 8'hFE, 1'b1);
    check("R6 hiz ch1", {6'b0, hiz1_en, hiz0_en}, 8'h02);
    rd_byte("R6 upper zero", 5'h01, 8'h02);
    check("R6 pos kept", pos0_code, 8'h12);
  endtask

  task automatic t_hole;
    wr_byte("R8 hole write", 5'h08, 8'h00, 1'b0);
    rd_byte("R8 hole read", 5'h08, 8'hFF);
    rd_byte("R8 hole read hi", 5'h0F, 8'hFF);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 5'h02; bus_wdata = 8'h00;
    #1;
    check("R10 no strobe", {7'b0, bus_wr_ok}, 8'h00);
  endtask

  task automatic t_lock;
    // setting hi=12 (still matched before), entry hi=12 matches again, then setting lo=34 locks
    wr_byte("R9 set hi", 5'h06, 8'h12, 1'b1);
    wr_byte("R9 locked set lo", 5'h07, 8'h34, 1'b0);
    wr_byte("R4 entry hi", 5'h04, 8'h12, 1'b1);
    wr_byte("R9 rematch set lo", 5'h07, 8'h34, 1'b1);
    rd_byte("R5 hidden hi", 5'h06, 8'hFF);
    rd_byte("R5 hidden lo", 5'h07, 8'hFF);
    wr_byte("R3 pos0 refused", 5'h02, 8'hAA, 1'b0);
    check("R3 pos0 kept", pos0_code, 8'h12);
    wr_byte("R3 user refused", 5'h10, 8'h00, 1'b0);
    rd_byte("R3 user kept", 5'h10, 8'h5A);
    wr_byte("R3 cfg refused", 5'h01, 8'h01, 1'b0);
    check("R3 hiz kept", {6'b0, hiz1_en, hiz0_en}, 8'h02);
    rd_byte("R4 entry reads ff", 5'h04, 8'hFF);
    wr_byte("R4 entry lo", 5'h05, 8'h34, 1'b1);
    rd_byte("R5 visible hi", 5'h06, 8'h12);
    rd_byte("R5 visible lo", 5'h07, 8'h34);
    rd_byte("R4 entry lo reads ff", 5'h05, 8'hFF);
    wr_byte("R2 pos0 after unlock", 5'h02, 8'hAA, 1'b1);
    check("R7 pos0 after unlock", pos0_code, 8'hAA);
  endtask

  task automatic t_break;
    wr_byte("R9 break entry", 5'h05, 8'h00, 1'b1);
    wr_byte("R9 next refused", 5'h02, 8'h55, 1'b0);
    check("R9 pos0 kept", pos0_code, 8'hAA);
    wr_byte("R9 entry still ok", 5'h05, 8'h34, 1'b1);
    wr_byte("R9 next accepted", 5'h02, 8'h55, 1'b1);
    check("R9 pos0 new", pos0_code, 8'h55);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_unlocked;
    t_config;
    t_hole;
    t_lock;
    t_break;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule